// File: doc/BRIEF.md
# Domain-Tagged DMA Address Translation and Permission Guard

This block sits in the path of device-initiated memory traffic. Each request names the device that issued it, an I/O address and whether it is a read or a write. The block first finds the device's protection domain and its device-level read and write permits in a small table. That table is loaded through a plain write port. It then searches a fully associative translation cache. Each cache entry is tagged with the pair {domain, I/O page number}, so every device placed in the same domain shares the same cached translations.

On a cache hit the access is allowed only if both the page-level and the device-level permit for its direction are set. The response then carries the translated system address, or a permission fault with a zeroed address. On a miss the block asks an external responder for the single page-table entry of that domain and page. It waits for the answer, fills the cache when the entry is present, and resolves the access against the fetched flags. An absent entry ends the request at once with a not-present fault; nothing is retried.

Only one request is in flight at a time. A ready/valid handshake on the request side holds off new work until the current response has been produced.

Top module: `dma_xlate_guard`

## Requirements
- R1: Each device ID resolves to the domain and device-level read/write permits last written for it through the configuration port. After reset, every device maps to domain 0 with both permits cleared. Rewriting a device's entry changes the domain used by its later requests.
- R2: The translation cache is keyed by {domain, I/O page number}, where the page number is address bits [31:12]. A second device in the same domain hits an entry filled by another device. The same page requested from a different domain misses.
- R3: On a hit, rsp_valid pulses for exactly one cycle, at the second rising edge after the request is accepted. A successful response has rsp_status = 0 and rsp_addr = {system page number, request address bits [11:0]}.
- R4: A read needs both the page read flag and the device read permit, and a write needs both the page write flag and the device write permit. When the needed pair is not both set, rsp_status = 1 (permission fault) and rsp_addr = 0.
- R5: On a miss, fetch_valid rises one cycle after the lookup cycle. It is held, with fetch_dom and fetch_vpn stable and equal to the request's domain and page, until the cycle in which fetch_rsp_valid is high. The response follows at the next rising edge.
- R6: A fetched entry with fetch_rsp_present low gives rsp_status = 2 (not-present fault) and rsp_addr = 0. It is not cached, so the same request misses again.
- R7: Every present fetched entry is cached, whether or not the access passes its permission check. The cache has 8 entries replaced in round-robin order, so the ninth distinct fill evicts the first.
- R8: req_ready is high only while no request is in progress. A req_valid presented while a request is in progress is ignored and produces no response.
- R9: After reset, req_ready is high and rsp_valid and fetch_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the device table |
| cfg_dev | input | 4 | Device ID whose table entry is written |
| cfg_dom | input | 4 | Domain assigned to that device |
| cfg_rd_en | input | 1 | Device-level read permit |
| cfg_wr_en | input | 1 | Device-level write permit |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_dev | input | 4 | Requesting device ID |
| req_addr | input | 32 | I/O address |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | 0 ok, 1 permission fault, 2 not-present fault |
| rsp_addr | output | 36 | Translated system address, 0 on fault |
| fetch_valid | output | 1 | Page-table entry fetch outstanding |
| fetch_dom | output | 4 | Domain of the fetched entry |
| fetch_vpn | output | 20 | I/O page number of the fetched entry |
| fetch_rsp_valid | input | 1 | Fetch answer present |
| fetch_rsp_present | input | 1 | Entry is present |
| fetch_rsp_rd | input | 1 | Page read flag |
| fetch_rsp_wr | input | 1 | Page write flag |
| fetch_rsp_ppn | input | 24 | System page number |

## Verification
The bench aims at the sharing rule: a second device in the same domain must hit. A design keyed on the device would fetch again, and one keyed on the page alone would hit across domains and leak another guest's mapping. It drives writes to read-only pages and requests from devices whose device-level permit is off. A design that checks only one level of flags would return an address there. It repeats not-present and permission-faulting requests, which exposes a design that caches absent entries or drops faulting fills. It fills past eight pages to check round-robin eviction. While a fetch is outstanding it holds req_valid high, which catches a design that accepts a second request or emits a spurious response.

// File: rtl/iotc_pkg.sv
package iotc_pkg;
    typedef enum logic [1:0] {
        XS_OK   = 2'd0,
        XS_PERM = 2'd1,
        XS_NP   = 2'd2
    } xl_status_e;

    typedef enum logic [1:0] {
        F_IDLE  = 2'd0,
        F_LOOK  = 2'd1,
        F_FETCH = 2'd2
    } xl_fsm_e;

    function automatic logic access_ok(input logic is_wr, input logic rd_ok, input logic wr_ok);
        return is_wr ? wr_ok : rd_ok;
    endfunction
endpackage

// File: rtl/dev_dom_table.sv
module dev_dom_table #(
    parameter int DEV_W = 4,
    parameter int DOM_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DEV_W-1:0] wr_dev,
    input  logic [DOM_W-1:0] wr_dom,
    input  logic             wr_rd,
    input  logic             wr_wr,
    input  logic [DEV_W-1:0] rd_dev,
    output logic [DOM_W-1:0] rd_dom,
    output logic             rd_rd,
    output logic             rd_wr
);
    localparam int NDEV = 1 << DEV_W;

    typedef struct packed {
        logic [DOM_W-1:0] dom;
        logic             rd;
        logic             wr;
    } dent_t;

    dent_t [NDEV-1:0] tab_d, tab_q;

    always_comb begin
        tab_d = tab_q;
        if (wr_en) begin
            tab_d[wr_dev] = '{dom: wr_dom, rd: wr_rd, wr: wr_wr};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tab_q <= '0;
        else        tab_q <= tab_d;
    end

    assign rd_dom = tab_q[rd_dev].dom;
    assign rd_rd  = tab_q[rd_dev].rd;
    assign rd_wr  = tab_q[rd_dev].wr;
endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb #(
    parameter int N_ENT = 8,
    parameter int DOM_W = 4,
    parameter int VPN_W = 20,
    parameter int PPN_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DOM_W-1:0] lk_dom,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic             lk_rd,
    output logic             lk_wr,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             fill_en,
    input  logic [DOM_W-1:0] fill_dom,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic             fill_rd,
    input  logic             fill_wr,
    input  logic [PPN_W-1:0] fill_ppn
);
    localparam int PTR_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    typedef struct packed {
        logic             v;
        logic [DOM_W-1:0] dom;
        logic [VPN_W-1:0] vpn;
        logic             rd;
        logic             wr;
        logic [PPN_W-1:0] ppn;
    } tent_t;

    typedef struct packed {
        tent_t [N_ENT-1:0] e;
        logic [PTR_W-1:0]  ptr;
    } tstate_t;

    tstate_t s_d, s_q;
    logic [N_ENT-1:0] match;

    for (genvar g = 0; g < N_ENT; g++) begin : g_match
        assign match[g] = s_q.e[g].v && (s_q.e[g].dom == lk_dom) && (s_q.e[g].vpn == lk_vpn);
    end

    always_comb begin
        lk_rd  = 1'b0;
        lk_wr  = 1'b0;
        lk_ppn = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (match[i]) begin
                lk_rd  = lk_rd  | s_q.e[i].rd;
                lk_wr  = lk_wr  | s_q.e[i].wr;
                lk_ppn = lk_ppn | s_q.e[i].ppn;
            end
        end
    end
    assign lk_hit = |match;

    always_comb begin
        s_d = s_q;
        if (fill_en) begin
            s_d.e[s_q.ptr] = '{v: 1'b1, dom: fill_dom, vpn: fill_vpn,
                               rd: fill_rd, wr: fill_wr, ppn: fill_ppn};
            s_d.ptr = (s_q.ptr == PTR_W'(N_ENT - 1)) ? '0 : s_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/dma_xlate_guard.sv
module dma_xlate_guard #(
    parameter int DEV_W    = 4,
    parameter int DOM_W    = 4,
    parameter int IOA_W    = 32,
    parameter int SYS_W    = 36,
    parameter int PG_SHIFT = 12,
    parameter int TLB_N    = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [DEV_W-1:0]          cfg_dev,
    input  logic [DOM_W-1:0]          cfg_dom,
    input  logic                      cfg_rd_en,
    input  logic                      cfg_wr_en,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [DEV_W-1:0]          req_dev,
    input  logic [IOA_W-1:0]          req_addr,
    input  logic                      req_write,
    output logic                      rsp_valid,
    output logic [1:0]                rsp_status,
    output logic [SYS_W-1:0]          rsp_addr,
    output logic                      fetch_valid,
    output logic [DOM_W-1:0]          fetch_dom,
    output logic [IOA_W-PG_SHIFT-1:0] fetch_vpn,
    input  logic                      fetch_rsp_valid,
    input  logic                      fetch_rsp_present,
    input  logic                      fetch_rsp_rd,
    input  logic                      fetch_rsp_wr,
    input  logic [SYS_W-PG_SHIFT-1:0] fetch_rsp_ppn
);
    import iotc_pkg::*;

    localparam int VPN_W = IOA_W - PG_SHIFT;
    localparam int PPN_W = SYS_W - PG_SHIFT;

    typedef struct packed {
        xl_fsm_e          fsm;
        logic [DEV_W-1:0] dev;
        logic [IOA_W-1:0] addr;
        logic             wr;
        logic [DOM_W-1:0] dom;
        logic             drd;
        logic             dwr;
        logic             rv;
        logic [1:0]       rst;
        logic [SYS_W-1:0] raddr;
    } gstate_t;

    gstate_t g_d, g_q;

    logic [DOM_W-1:0] tab_dom;
    logic             tab_rd, tab_wr;
    logic             hit, hit_rd, hit_wr;
    logic [PPN_W-1:0] hit_ppn;
    logic             fill_en;

    dev_dom_table #(.DEV_W(DEV_W), .DOM_W(DOM_W)) u_dtab (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_dev (cfg_dev),
        .wr_dom (cfg_dom),
        .wr_rd  (cfg_rd_en),
        .wr_wr  (cfg_wr_en),
        .rd_dev (g_q.dev),
        .rd_dom (tab_dom),
        .rd_rd  (tab_rd),
        .rd_wr  (tab_wr)
    );

    xlate_tlb #(.N_ENT(TLB_N), .DOM_W(DOM_W), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_tlb (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_dom   (tab_dom),
        .lk_vpn   (g_q.addr[IOA_W-1:PG_SHIFT]),
        .lk_hit   (hit),
        .lk_rd    (hit_rd),
        .lk_wr    (hit_wr),
        .lk_ppn   (hit_ppn),
        .fill_en  (fill_en),
        .fill_dom (g_q.dom),
        .fill_vpn (g_q.addr[IOA_W-1:PG_SHIFT]),
        .fill_rd  (fetch_rsp_rd),
        .fill_wr  (fetch_rsp_wr),
        .fill_ppn (fetch_rsp_ppn)
    );

    always_comb begin
        g_d     = g_q;
        g_d.rv  = 1'b0;
        fill_en = 1'b0;
        unique case (g_q.fsm)
            F_IDLE: begin
                if (req_valid) begin
                    g_d.dev  = req_dev;
                    g_d.addr = req_addr;
                    g_d.wr   = req_write;
                    g_d.fsm  = F_LOOK;
                end
            end
            F_LOOK: begin
                g_d.dom = tab_dom;
                g_d.drd = tab_rd;
                g_d.dwr = tab_wr;
                if (hit) begin
                    g_d.rv  = 1'b1;
                    g_d.fsm = F_IDLE;
                    if (access_ok(g_q.wr, hit_rd & tab_rd, hit_wr & tab_wr)) begin
                        g_d.rst   = XS_OK;
                        g_d.raddr = {hit_ppn, g_q.addr[PG_SHIFT-1:0]};
                    end else begin
                        g_d.rst   = XS_PERM;
                        g_d.raddr = '0;
                    end
                end else begin
                    g_d.fsm = F_FETCH;
                end
            end
            F_FETCH: begin
                if (fetch_rsp_valid) begin
                    g_d.rv    = 1'b1;
                    g_d.fsm   = F_IDLE;
                    g_d.raddr = '0;
                    if (!fetch_rsp_present) begin
                        g_d.rst = XS_NP;
                    end else begin
                        fill_en = 1'b1;
                        if (access_ok(g_q.wr, fetch_rsp_rd & g_q.drd, fetch_rsp_wr & g_q.dwr)) begin
                            g_d.rst   = XS_OK;
                            g_d.raddr = {fetch_rsp_ppn, g_q.addr[PG_SHIFT-1:0]};
                        end else begin
                            g_d.rst = XS_PERM;
                        end
                    end
                end
            end
            default: g_d.fsm = F_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_q     <= '0;
            g_q.fsm <= F_IDLE;
        end else begin
            g_q <= g_d;
        end
    end

    assign req_ready   = (g_q.fsm == F_IDLE);
    assign fetch_valid = (g_q.fsm == F_FETCH);
    assign fetch_dom   = g_q.dom;
    assign fetch_vpn   = g_q.addr[IOA_W-1:PG_SHIFT];
    assign rsp_valid   = g_q.rv;
    assign rsp_status  = g_q.rst;
    assign rsp_addr    = g_q.raddr;
endmodule

// File: rtl/dma_xlate_guard_chk.sv
module dma_xlate_guard_chk #(
    parameter int DOM_W    = 4,
    parameter int IOA_W    = 32,
    parameter int SYS_W    = 36,
    parameter int PG_SHIFT = 12
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      req_valid,
    input logic                      req_ready,
    input logic                      rsp_valid,
    input logic [1:0]                rsp_status,
    input logic [SYS_W-1:0]          rsp_addr,
    input logic                      fetch_valid,
    input logic [DOM_W-1:0]          fetch_dom,
    input logic [IOA_W-PG_SHIFT-1:0] fetch_vpn,
    input logic                      fetch_rsp_valid
);
    // R8
    accept_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !rsp_valid));

    // R8
    no_accept_during_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> !req_ready);

    // R5
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !fetch_rsp_valid) |=> (fetch_valid && $stable(fetch_dom) && $stable(fetch_vpn)));

    // R5
    fetch_answer_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_rsp_valid) |=> (rsp_valid && !fetch_valid));

    // R3
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R4
    fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status != 2'd0) |-> (rsp_addr == '0));

    // R6
    status_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_status != 2'd3));
endmodule

bind dma_xlate_guard dma_xlate_guard_chk #(
    .DOM_W(DOM_W), .IOA_W(IOA_W), .SYS_W(SYS_W), .PG_SHIFT(PG_SHIFT)
) u_chk (.*);

// File: tb/dma_xlate_guard_test.sv
`timescale 1ns/1ps
module dma_xlate_guard_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_dev = '0;
    logic [3:0]  cfg_dom = '0;
    logic        cfg_rd_en = 1'b0, cfg_wr_en = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_dev = '0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [35:0] rsp_addr;
    logic        fetch_valid;
    logic [3:0]  fetch_dom;
    logic [19:0] fetch_vpn;
    logic        fetch_rsp_valid = 1'b0, fetch_rsp_present = 1'b0;
    logic        fetch_rsp_rd = 1'b0, fetch_rsp_wr = 1'b0;
    logic [23:0] fetch_rsp_ppn = '0;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [3:0]  m_dom [16];
    logic        m_drd [16];
    logic        m_dwr [16];
    logic        t_v   [8];
    logic [3:0]  t_dom [8];
    logic [19:0] t_vpn [8];
    logic        t_rd  [8];
    logic        t_wr  [8];
    logic [23:0] t_ppn [8];
    int          rr = 0;

    always #2 clk = ~clk;

    dma_xlate_guard uut (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // page-table contents seen by the responder
    function automatic logic pt_present(input logic [19:0] vpn);
        return vpn[3:0] != 4'hF;
    endfunction
    function automatic logic pt_rd(input logic [19:0] vpn);
        return !vpn[4];
    endfunction
    function automatic logic pt_wr(input logic [19:0] vpn);
        return vpn[5];
    endfunction
    function automatic logic [23:0] pt_ppn(input logic [3:0] dom, input logic [19:0] vpn);
        return {dom, vpn} ^ 24'hA5C3F0;
    endfunction

    task automatic cfg(input logic [3:0] dev, input logic [3:0] dom, input logic rd, input logic wr);
        @(negedge clk);
        cfg_we = 1'b1; cfg_dev = dev; cfg_dom = dom; cfg_rd_en = rd; cfg_wr_en = wr;
        @(negedge clk);
        cfg_we = 1'b0;
        m_dom[dev] = dom; m_drd[dev] = rd; m_dwr[dev] = wr;
    endtask

    task automatic do_req(input string tag, input logic [3:0] dev, input logic [31:0] addr,
                          input logic wr, input int delay, input bit junk);
        logic [3:0]  dom = m_dom[dev];
        logic [19:0] vpn = addr[31:12];
        int          hit_i = -1;
        logic        prd, pwr, ok;
        logic [23:0] ppn;
        logic [1:0]  est;
        logic [35:0] eaddr;
        for (int i = 0; i < 8; i++)
            if (t_v[i] && t_dom[i] == dom && t_vpn[i] == vpn) hit_i = i;
        @(negedge clk);
        check({tag, " R8 ready idle"}, req_ready, 1'b1);
        req_valid = 1'b1; req_dev = dev; req_addr = addr; req_write = wr;
        @(negedge clk);
        req_valid = junk; req_dev = ~dev; req_addr = ~addr;
        check({tag, " R8 busy"}, {req_ready, rsp_valid, fetch_valid}, 3'b000);
        @(negedge clk);
        if (hit_i >= 0) begin
            check({tag, " R2 hit"}, fetch_valid, 1'b0);
            prd = t_rd[hit_i]; pwr = t_wr[hit_i]; ppn = t_ppn[hit_i];
        end else begin
            check({tag, " R2/R5 miss fetch"}, fetch_valid, 1'b1);
            check({tag, " R5 fetch key"}, {fetch_dom, fetch_vpn}, {dom, vpn});
            for (int k = 0; k < delay; k++) begin
                @(negedge clk);
                check({tag, " R5 fetch held"}, {fetch_valid, rsp_valid, req_ready, fetch_dom, fetch_vpn},
                      {3'b100, dom, vpn});
            end
            req_valid = 1'b0;
            fetch_rsp_valid = 1'b1; fetch_rsp_present = pt_present(vpn);
            fetch_rsp_rd = pt_rd(vpn); fetch_rsp_wr = pt_wr(vpn); fetch_rsp_ppn = pt_ppn(dom, vpn);
            @(negedge clk);
            fetch_rsp_valid = 1'b0;
            prd = pt_rd(vpn); pwr = pt_wr(vpn); ppn = pt_ppn(dom, vpn);
            if (pt_present(vpn)) begin
                t_v[rr] = 1'b1; t_dom[rr] = dom; t_vpn[rr] = vpn;
                t_rd[rr] = prd; t_wr[rr] = pwr; t_ppn[rr] = ppn;
                rr = (rr + 1) % 8;
            end
        end
        req_valid = 1'b0;
        ok = wr ? (pwr && m_dwr[dev]) : (prd && m_drd[dev]);
        if (hit_i < 0 && !pt_present(vpn)) begin
            est = 2'd2; eaddr = '0;
        end else if (ok) begin
            est = 2'd0; eaddr = {ppn, addr[11:0]};
        end else begin
            est = 2'd1; eaddr = '0;
        end
        check({tag, " R3 rsp_valid"}, rsp_valid, 1'b1);
        check({tag, " R3/R4/R6 status"}, rsp_status, est);
        check({tag, " R3/R4 addr"}, rsp_addr, eaddr);
        check({tag, " R8 ready after"}, {req_ready, fetch_valid}, 2'b10);
        @(negedge clk);
        check({tag, " R3/R8 single pulse"}, rsp_valid, 1'b0);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin m_dom[i] = '0; m_drd[i] = 1'b0; m_dwr[i] = 1'b0; end
        for (int i = 0; i < 8; i++) t_v[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset outputs", {req_ready, rsp_valid, fetch_valid}, 3'b100);

        // R1: unconfigured device resolves to domain 0 with no permits
        do_req("R1 reset entry", 4'd9, 32'h0000_7ABC, 1'b0, 1, 1'b0);

        cfg(4'd1, 4'd3, 1'b1, 1'b1);
        cfg(4'd2, 4'd3, 1'b1, 1'b1);
        cfg(4'd3, 4'd5, 1'b1, 1'b0);

        do_req("R5 first fill", 4'd1, 32'h0000_0123, 1'b0, 2, 1'b0);
        do_req("R2 shared domain", 4'd2, 32'h0000_0FFE, 1'b0, 0, 1'b0);
        do_req("R2 other domain", 4'd3, 32'h0000_0456, 1'b0, 1, 1'b0);
        do_req("R4 page ro write", 4'd1, 32'h0000_0010, 1'b1, 0, 1'b0);
        do_req("R4 write ok", 4'd1, 32'h0002_0044, 1'b1, 0, 1'b0);
        do_req("R4 device no wr", 4'd3, 32'h0002_0048, 1'b1, 3, 1'b0);
        do_req("R6 not present", 4'd1, 32'h0000_F000, 1'b0, 1, 1'b0);
        do_req("R6 not cached", 4'd2, 32'h0000_F004, 1'b0, 0, 1'b0);
        do_req("R7 fault fill", 4'd1, 32'h0001_0800, 1'b0, 1, 1'b0);
        do_req("R7 fault hit", 4'd2, 32'h0001_0804, 1'b0, 0, 1'b0);
        do_req("R8 junk ignored", 4'd2, 32'h0003_1111, 1'b0, 3, 1'b1);

        for (int p = 0; p < 9; p++)
            do_req("R7 round robin", 4'd1, {12'h100, p[3:0], 16'h0230}, p[0], p % 3, 1'b0);
        do_req("R7 evicted", 4'd1, 32'h0000_0123, 1'b0, 1, 1'b0);

        cfg(4'd2, 4'd6, 1'b1, 1'b1);
        do_req("R1 remap domain", 4'd2, 32'h0000_0123, 1'b0, 0, 1'b0);
        do_req("R1 remap hit", 4'd2, 32'h0000_0321, 1'b0, 0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule